// File: doc/BRIEF.md
# Accumulator Execute Unit (Swap, XOR and Direction Load)

This block is the execute stage of a small 8-bit accumulator-style controller core, trimmed to four operations. It receives an operation that is already decoded, along with a file address, a destination-select bit and an immediate byte. In a single clock it performs one of four actions:

- exchange the two nibbles of a file register;
- XOR the accumulator with the immediate;
- XOR the accumulator with a file register;
- copy the accumulator into one of three pin-direction registers.

The block holds the accumulator, a file of 2^ADDR_W data registers, the direction registers and a zero flag. Read-only observation ports show the accumulator, the flag, the direction registers and one file register chosen by address. A surrounding core or a testbench can compare these against a model.

Reset is asynchronous and active low on `rst_n`. Inside the block it is released synchronously through a two-stage synchronizer, so state leaves reset two clock edges after `rst_n` rises.

Top module: `acc_exec_unit`

## Requirements
- R1: While reset is applied and after it, the accumulator is 0x00, the zero flag is 0, each direction register is 0xFF and every file register is 0x00.
- R2: The swap operation (code 0) produces a result whose bits 7:4 are source bits 3:0 and whose bits 3:0 are source bits 7:4.
- R3: For swap (code 0) and file XOR (code 2), a destination bit of 0 writes the result to the accumulator and leaves the file register unchanged. A destination bit of 1 writes it to the addressed file register and leaves the accumulator unchanged.
- R4: The swap operation leaves the zero flag unchanged.
- R5: The literal XOR (code 1) writes accumulator XOR immediate to the accumulator. It sets the zero flag exactly when that result is 0x00 and changes no file register.
- R6: The file XOR (code 2) computes accumulator XOR the addressed file register and sets the zero flag exactly when that result is 0x00.
- R7: The direction load (code 3) copies the accumulator into register A for address 5, B for address 6 and C for address 7. It leaves the accumulator and zero flag unchanged.
- R8: A direction load whose address is outside 5 to 7 changes no state.
- R9: With `op_valid` low, no state changes, whatever the other operation inputs are.
- R10: An operation presented with `op_valid` high at a rising edge is complete, and its result is visible on the observation ports, right after that edge.
- R11: All 128 file addresses, including address 127, are reachable for reading and writing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Execute the presented operation on this edge |
| op_code | input | 2 | 0 swap, 1 literal XOR, 2 file XOR, 3 direction load |
| op_addr | input | 7 | File address, or direction-register selector |
| op_dest | input | 1 | 0 result to accumulator, 1 result to file register |
| op_lit | input | 8 | Immediate byte for literal XOR |
| dbg_addr | input | 7 | File address shown on dbg_file |
| dbg_file | output | 8 | Content of the file register at dbg_addr |
| dbg_w | output | 8 | Accumulator |
| dbg_zero | output | 1 | Zero flag |
| dbg_dir_a | output | 8 | Direction register A |
| dbg_dir_b | output | 8 | Direction register B |
| dbg_dir_c | output | 8 | Direction register C |

## Verification
The bench builds the block with its default parameters: an 8-bit data path, a 7-bit file address and the direction window starting at address 5. With these values the top file address 127 can be exercised directly. The same holds for both neighbours of the direction window, addresses 4 and 8, and for address 0, which must all be ignored by a direction load. The 8-bit data path also makes the nibble swap and the zero-result XOR cases concrete, byte-level expectations.

// File: rtl/aeu_pkg.sv
package aeu_pkg;
  typedef enum logic [1:0] {
    OP_SWAP  = 2'd0,
    OP_XORL  = 2'd1,
    OP_XORF  = 2'd2,
    OP_DIRLD = 2'd3
  } aeu_op_e;
endpackage

// File: rtl/aeu_alu.sv
module aeu_alu
  import aeu_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  aeu_op_e           op,
  input  logic [DATA_W-1:0] acc,
  input  logic [DATA_W-1:0] fval,
  input  logic [DATA_W-1:0] imm,
  output logic [DATA_W-1:0] result,
  output logic              zero
);
  localparam int HALF = DATA_W / 2;

  logic [DATA_W-1:0] swapped;

  assign swapped = {fval[HALF-1:0], fval[DATA_W-1:HALF]};

  always_comb begin
    case (op)
      OP_SWAP: result = swapped;
      OP_XORL: result = acc ^ imm;
      OP_XORF: result = acc ^ fval;
      default: result = acc;
    endcase
  end

  assign zero = (result == '0);
endmodule

// File: rtl/aeu_regfile.sv
module aeu_regfile #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr_a,
  output logic [DATA_W-1:0] rdata_a,
  input  logic [ADDR_W-1:0] raddr_b,
  output logic [DATA_W-1:0] rdata_b
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_entry
    logic hit;
    assign hit = we && (waddr == ADDR_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   mem[g] <= '0;
      else if (hit) mem[g] <= wdata;
    end
  end

  assign rdata_a = mem[raddr_a];
  assign rdata_b = mem[raddr_b];
endmodule

// File: rtl/aeu_dirregs.sv
module aeu_dirregs #(
  parameter int DATA_W    = 8,
  parameter int ADDR_W    = 7,
  parameter int DIR_BASE  = 5,
  parameter int DIR_COUNT = 3
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               ld_en,
  input  logic [ADDR_W-1:0]                  ld_addr,
  input  logic [DATA_W-1:0]                  ld_data,
  output logic [DIR_COUNT-1:0][DATA_W-1:0]   dir_q
);
  for (genvar g = 0; g < DIR_COUNT; g++) begin : g_dir
    logic sel;
    assign sel = ld_en && (ld_addr == ADDR_W'(DIR_BASE + g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   dir_q[g] <= '1;
      else if (sel) dir_q[g] <= ld_data;
    end
  end
endmodule

// File: rtl/acc_exec_unit.sv
module acc_exec_unit
  import aeu_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int ADDR_W   = 7,
  parameter int DIR_BASE = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_valid,
  input  logic [1:0]        op_code,
  input  logic [ADDR_W-1:0] op_addr,
  input  logic              op_dest,
  input  logic [DATA_W-1:0] op_lit,
  input  logic [ADDR_W-1:0] dbg_addr,
  output logic [DATA_W-1:0] dbg_file,
  output logic [DATA_W-1:0] dbg_w,
  output logic              dbg_zero,
  output logic [DATA_W-1:0] dbg_dir_a,
  output logic [DATA_W-1:0] dbg_dir_b,
  output logic [DATA_W-1:0] dbg_dir_c
);
  localparam int DIR_COUNT = 3;
  localparam int SYNC_LEN  = 2;

  // reset: asserted asynchronously, released on the clock
  logic [SYNC_LEN-1:0] rst_pipe;
  logic                rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[SYNC_LEN-2:0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[SYNC_LEN-1];

  aeu_op_e           op;
  logic [DATA_W-1:0] w_q, w_nxt;
  logic              w_en;
  logic              z_q, z_nxt, z_en;
  logic              file_we;
  logic              dir_en;
  logic [DATA_W-1:0] file_rd;
  logic [DATA_W-1:0] alu_res;
  logic              alu_zero;
  logic [DIR_COUNT-1:0][DATA_W-1:0] dir_q;

  assign op = aeu_op_e'(op_code);

  aeu_alu #(.DATA_W(DATA_W)) u_alu (
    .op     (op),
    .acc    (w_q),
    .fval   (file_rd),
    .imm    (op_lit),
    .result (alu_res),
    .zero   (alu_zero)
  );

  aeu_regfile #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_file (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .we      (file_we),
    .waddr   (op_addr),
    .wdata   (alu_res),
    .raddr_a (op_addr),
    .rdata_a (file_rd),
    .raddr_b (dbg_addr),
    .rdata_b (dbg_file)
  );

  aeu_dirregs #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .DIR_BASE(DIR_BASE), .DIR_COUNT(DIR_COUNT)
  ) u_dir (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .ld_en   (dir_en),
    .ld_addr (op_addr),
    .ld_data (w_q),
    .dir_q   (dir_q)
  );

  // next-state decode
  always_comb begin
    w_nxt   = alu_res;
    z_nxt   = alu_zero;
    w_en    = 1'b0;
    z_en    = 1'b0;
    file_we = 1'b0;
    dir_en  = 1'b0;
    if (op_valid) begin
      case (op)
        OP_SWAP: begin
          file_we = op_dest;
          w_en    = !op_dest;
        end
        OP_XORL: begin
          w_en = 1'b1;
          z_en = 1'b1;
        end
        OP_XORF: begin
          file_we = op_dest;
          w_en    = !op_dest;
          z_en    = 1'b1;
        end
        default: dir_en = 1'b1;
      endcase
    end
  end

  // state registers
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) w_q <= '0;
    else if (w_en)   w_q <= w_nxt;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) z_q <= 1'b0;
    else if (z_en)   z_q <= z_nxt;
  end

  assign dbg_w     = w_q;
  assign dbg_zero  = z_q;
  assign dbg_dir_a = dir_q[0];
  assign dbg_dir_b = dir_q[1];
  assign dbg_dir_c = dir_q[2];
endmodule

// File: rtl/acc_exec_unit_chk.sv
module acc_exec_unit_chk #(
  parameter int DATA_W   = 8,
  parameter int ADDR_W   = 7,
  parameter int DIR_BASE = 5
) (
  input logic              clk,
  input logic              rst_sync_n,
  input logic              op_valid,
  input logic [1:0]        op_code,
  input logic [ADDR_W-1:0] op_addr,
  input logic              op_dest,
  input logic [DATA_W-1:0] op_lit,
  input logic [DATA_W-1:0] dbg_w,
  input logic              dbg_zero,
  input logic [DATA_W-1:0] dbg_dir_a,
  input logic [DATA_W-1:0] dbg_dir_b,
  input logic [DATA_W-1:0] dbg_dir_c
);
  logic dir_out_of_window;
  assign dir_out_of_window = (op_addr < ADDR_W'(DIR_BASE)) || (op_addr > ADDR_W'(DIR_BASE + 2));

  assert_reset_values_R1: assert property (@(posedge clk)
    $rose(rst_sync_n) |-> (dbg_w == '0) && !dbg_zero &&
      (dbg_dir_a == '1) && (dbg_dir_b == '1) && (dbg_dir_c == '1));

  assert_dest_file_keeps_w_R3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    op_valid && op_dest && ((op_code == 2'd0) || (op_code == 2'd2)) |=> $stable(dbg_w));

  assert_swap_keeps_zero_R4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    op_valid && (op_code == 2'd0) |=> $stable(dbg_zero));

  assert_xorl_result_R5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    op_valid && (op_code == 2'd1) |=> dbg_w == ($past(dbg_w) ^ $past(op_lit)));

  assert_xorl_zero_R5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    op_valid && (op_code == 2'd1) |=> dbg_zero == (dbg_w == '0));

  assert_dirld_keeps_w_z_R7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    op_valid && (op_code == 2'd3) |=> $stable(dbg_w) && $stable(dbg_zero));

  assert_dirld_outside_ignored_R8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    op_valid && (op_code == 2'd3) && dir_out_of_window |=>
      $stable(dbg_dir_a) && $stable(dbg_dir_b) && $stable(dbg_dir_c));

  assert_idle_holds_R9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !op_valid |=> $stable(dbg_w) && $stable(dbg_zero) &&
      $stable(dbg_dir_a) && $stable(dbg_dir_b) && $stable(dbg_dir_c));

  assert_dirld_a_R10: assert property (@(posedge clk) disable iff (!rst_sync_n)
    op_valid && (op_code == 2'd3) && (op_addr == ADDR_W'(DIR_BASE)) |=> dbg_dir_a == $past(dbg_w));
endmodule

bind acc_exec_unit acc_exec_unit_chk #(
  .DATA_W(DATA_W), .ADDR_W(ADDR_W), .DIR_BASE(DIR_BASE)
) u_chk (
  .clk        (clk),
  .rst_sync_n (rst_sync_n),
  .op_valid   (op_valid),
  .op_code    (op_code),
  .op_addr    (op_addr),
  .op_dest    (op_dest),
  .op_lit     (op_lit),
  .dbg_w      (dbg_w),
  .dbg_zero   (dbg_zero),
  .dbg_dir_a  (dbg_dir_a),
  .dbg_dir_b  (dbg_dir_b),
  .dbg_dir_c  (dbg_dir_c)
);

// File: tb/acc_exec_unit_bench.sv
`timescale 1ns/1ps
module acc_exec_unit_bench;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       op_valid;
  logic [1:0] op_code;
  logic [6:0] op_addr;
  logic       op_dest;
  logic [7:0] op_lit;
  logic [6:0] dbg_addr;
  logic [7:0] dbg_file, dbg_w, dbg_dir_a, dbg_dir_b, dbg_dir_c;
  logic       dbg_zero;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  // model state
  logic [7:0] m_w;
  logic       m_z;
  logic [7:0] m_dir [3];
  logic [7:0] m_file [128];

  always #2.5 clk = ~clk;

  acc_exec_unit u_acc_exec_unit (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
    .op_addr(op_addr), .op_dest(op_dest), .op_lit(op_lit), .dbg_addr(dbg_addr),
    .dbg_file(dbg_file), .dbg_w(dbg_w), .dbg_zero(dbg_zero),
    .dbg_dir_a(dbg_dir_a), .dbg_dir_b(dbg_dir_b), .dbg_dir_c(dbg_dir_c)
  );

  task automatic chk(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic check_all(input string req, input logic [6:0] a);
    dbg_addr = a;
    #1;
    chk(req, "acc",   dbg_w, m_w);
    chk(req, "zero",  {7'd0, dbg_zero}, {7'd0, m_z});
    chk(req, "dir_a", dbg_dir_a, m_dir[0]);
    chk(req, "dir_b", dbg_dir_b, m_dir[1]);
    chk(req, "dir_c", dbg_dir_c, m_dir[2]);
    chk(req, "file",  dbg_file, m_file[a]);
  endtask

  task automatic do_op(input logic v, input logic [1:0] op, input logic [6:0] a,
                       input logic d, input logic [7:0] k);
    logic [7:0] res;
    @(negedge clk);
    op_valid = v; op_code = op; op_addr = a; op_dest = d; op_lit = k;
    if (v) begin
      case (op)
        2'd0: begin
          res = {m_file[a][3:0], m_file[a][7:4]};
          if (d) m_file[a] = res; else m_w = res;
        end
        2'd1: begin
          res = m_w ^ k; m_w = res; m_z = (res == 8'h00);
        end
        2'd2: begin
          res = m_w ^ m_file[a]; m_z = (res == 8'h00);
          if (d) m_file[a] = res; else m_w = res;
        end
        default: if (a >= 7'd5 && a <= 7'd7) m_dir[a - 7'd5] = m_w;
      endcase
    end
    @(negedge clk);
    op_valid = 1'b0;
  endtask

  // place value v in file register a (register must hold 0 beforehand)
  task automatic load_file(input logic [6:0] a, input logic [7:0] v);
    do_op(1, 2'd1, 7'd0, 0, m_w ^ v);
    do_op(1, 2'd2, a, 1, 8'h00);
  endtask

  task automatic t_reset;
    check_all("R1", 7'd0);
    check_all("R1", 7'd127);
    check_all("R1", 7'd64);
  endtask

  task automatic t_xor_literal;
    do_op(1, 2'd1, 7'd3, 1, 8'h5A);
    check_all("R5_R10", 7'd3);
    do_op(1, 2'd1, 7'd3, 0, 8'h5A);
    check_all("R5_zero", 7'd3);
    do_op(1, 2'd1, 7'd3, 0, 8'h81);
    check_all("R5_clear", 7'd3);
  endtask

  task automatic t_swap;
    load_file(7'd10, 8'h3C);
    check_all("R6_load", 7'd10);
    do_op(1, 2'd0, 7'd10, 0, 8'h00);
    check_all("R2_R3_to_acc", 7'd10);
    do_op(1, 2'd0, 7'd10, 1, 8'h00);
    check_all("R2_R3_to_file", 7'd10);
    do_op(1, 2'd1, 7'd0, 0, m_w);
    check_all("R5_setz", 7'd10);
    do_op(1, 2'd0, 7'd10, 0, 8'h00);
    check_all("R4_zero_kept", 7'd10);
  endtask

  task automatic t_xor_file;
    load_file(7'd20, 8'hA5);
    do_op(1, 2'd1, 7'd0, 0, m_w ^ 8'h0F);
    do_op(1, 2'd2, 7'd20, 0, 8'h00);
    check_all("R6_R3_to_acc", 7'd20);
    do_op(1, 2'd2, 7'd20, 1, 8'h00);
    check_all("R6_R3_to_file", 7'd20);
    do_op(1, 2'd1, 7'd0, 0, m_w ^ m_file[20]);
    do_op(1, 2'd2, 7'd20, 1, 8'h00);
    check_all("R6_zero", 7'd20);
  endtask

  task automatic t_dir_load;
    do_op(1, 2'd1, 7'd0, 0, m_w ^ 8'h12);
    do_op(1, 2'd3, 7'd5, 0, 8'h00);
    check_all("R7_a", 7'd5);
    do_op(1, 2'd1, 7'd0, 0, m_w ^ 8'h34);
    do_op(1, 2'd3, 7'd6, 1, 8'h00);
    check_all("R7_b", 7'd6);
    do_op(1, 2'd1, 7'd0, 0, m_w ^ 8'h56);
    do_op(1, 2'd3, 7'd7, 0, 8'h00);
    check_all("R7_c", 7'd7);
  endtask

  task automatic t_dir_outside;
    do_op(1, 2'd1, 7'd0, 0, m_w ^ 8'hEE);
    do_op(1, 2'd3, 7'd4, 0, 8'h00);
    check_all("R8_addr4", 7'd4);
    do_op(1, 2'd3, 7'd8, 1, 8'h00);
    check_all("R8_addr8", 7'd8);
    do_op(1, 2'd3, 7'd0, 0, 8'h00);
    check_all("R8_addr0", 7'd0);
  endtask

  task automatic t_idle;
    load_file(7'd30, 8'h77);
    do_op(0, 2'd1, 7'd30, 0, 8'hFF);
    check_all("R9_xorl", 7'd30);
    do_op(0, 2'd0, 7'd30, 1, 8'h00);
    check_all("R9_swap", 7'd30);
    do_op(0, 2'd3, 7'd5, 0, 8'h00);
    check_all("R9_dir", 7'd5);
  endtask

  task automatic t_top_addr;
    load_file(7'd127, 8'hC9);
    check_all("R11_load", 7'd127);
    do_op(1, 2'd0, 7'd127, 1, 8'h00);
    check_all("R11_swap", 7'd127);
    check_all("R11_neighbour", 7'd126);
  endtask

  initial begin
    rst_n = 1'b0; op_valid = 1'b0; op_code = 2'd0; op_addr = '0;
    op_dest = 1'b0; op_lit = '0; dbg_addr = '0;
    m_w = 8'h00; m_z = 1'b0;
    for (int i = 0; i < 3; i++) m_dir[i] = 8'hFF;
    for (int i = 0; i < 128; i++) m_file[i] = 8'h00;
    repeat (3) @(negedge clk);
    check_all("R1_in_reset", 7'd1);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_xor_literal();
    t_swap();
    t_xor_file();
    t_dir_load();
    t_dir_outside();
    t_idle();
    t_top_addr();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule